// File: doc/BRIEF.md
# Protected SRAM Bus Interface

This block is a byte-wide static memory behind an asynchronous, active-low bus made of a chip select, an output enable, a write strobe, an address and a data bus. A fast internal clock samples the three control pins through a two-stage synchronizer. Synchronous logic then decides when a read or a write is in progress, when the data drivers are on, and at which moments a write window opens and closes. The memory holds 2**AW bytes. Setting AW=15 gives the full 32,768-byte array. The default is kept smaller so that the default elaboration stays light.

The data bus is split into an input, an output and an output-enable line. The pad's tristate buffer sits outside this block. A write window opens on the later of the chip-select and write-strobe falling edges and closes on the earlier of their rising edges. The byte is stored at the close, at the address captured when the window opened. While the supply-fault input is high, every write is suppressed. Access latency, the recovery time after a write and the delay before the drivers turn off are all counted in internal clock cycles.

Top module: `sram_bus_port`

## Requirements
- R1: After reset `dq_oe` and `addr_moved` are 0, and the recovery interval counts as already met, so the first write is accepted.
- R2: A byte written at any address reads back unchanged, and other addresses keep their contents.
- R3: `dq_oe` is 1 only while the synchronized `ce_n` and `oe_n` are both low. A pin change reaches `dq_oe` two clock edges after it is sampled.
- R4: While driving, `dq_o` is all zeros until ACC_LAT cycles after `oe_n`/`ce_n` became active internally, or ACC_LAT+1 cycles after an address change. After that it carries the stored byte.
- R5: A write window opens on the later falling edge of `ce_n` and `we_n` and closes on the earlier rising edge. The byte committed is the last `dq_i` value sampled inside the window, and data changed after the close is not stored.
- R6: If the drivers are on when `we_n` falls, `dq_oe` stays 1 for ODIS_DLY cycles after the synchronized fall and then goes to 0.
- R7: After a write closes, `we_n` must be high for at least RECOVERY+1 pin cycles before a new window can open. A window that starts earlier is ignored until both `ce_n` and `we_n` have gone high again.
- R8: While `supply_fault` is 1, no window opens and an open window is aborted without a commit.
- R9: The address is captured when the window opens, and the commit goes to that captured address. `addr_moved` becomes 1 if the address changes while the window is open, and it is cleared when the next window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| dq_i | input | DW | Data from the bus pins |
| supply_fault | input | 1 | High while the supply is out of tolerance |
| dq_o | output | DW | Data toward the bus pins |
| dq_oe | output | 1 | Drive enable for the bus pins |
| addr_moved | output | 1 | Address changed during the last write window |

## Verification
The whole of a 16-byte configuration is written and read back with three arithmetic patterns: an affine byte, its complement and a walking one. Together these separate stuck or swapped data bits from aliased addresses. The write-window tests drive each edge order of chip select and write strobe, and change the data both inside and after the window. These tests tell a correct open/close choice apart from one that uses only one of the two pins. The recovery gap is tried at exactly RECOVERY and at RECOVERY+1 high cycles, and the supply fault is raised both before a write and in the middle of one. The bench also watches the latency and driver-disable edges cycle by cycle.

// File: rtl/sram_bus_port.sv
module sram_bus_port #(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int RECOVERY = 4,
  parameter int ODIS_DLY = 2,
  parameter int ACC_LAT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_i,
  input  logic          supply_fault,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          addr_moved
);
  localparam int DEPTH = 1 << AW;
  localparam int RW = $clog2(RECOVERY + 2);
  localparam int OW = $clog2(ODIS_DLY + 2);
  localparam int LW = $clog2(ACC_LAT + 2);

  logic [2:0] sync1, sync2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '1;
      sync2 <= '1;
    end else begin
      sync1 <= {ce_n, oe_n, we_n};
      sync2 <= sync1;
    end

  wire ce_s = sync2[2];
  wire oe_s = sync2[1];
  wire we_s = sync2[0];
  wire wr_act = !ce_s && !we_s;

  logic          wr_act_q, win, moved_q;
  logic [AW-1:0] addr_q, addr_lat;
  logic [DW-1:0] wdata;
  logic [RW-1:0] rec_cnt;
  logic [OW-1:0] we_lo_cnt;
  logic [LW-1:0] acc_cnt;
  logic [DW-1:0] mem [DEPTH];

  wire rec_ok   = rec_cnt == RW'(RECOVERY);
  wire open_ev  = wr_act && !wr_act_q && !win && rec_ok && !supply_fault;
  wire close_ev = win && !wr_act;
  wire commit   = close_ev && !supply_fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      win       <= 1'b0;
      moved_q   <= 1'b0;
      addr_q    <= '0;
      addr_lat  <= '0;
      wdata     <= '0;
      rec_cnt   <= RW'(RECOVERY);
      we_lo_cnt <= '0;
      acc_cnt   <= '0;
    end else begin
      wr_act_q <= wr_act;
      addr_q   <= addr;
      if (open_ev) begin
        win      <= 1'b1;
        addr_lat <= addr;
        moved_q  <= 1'b0;
        wdata    <= dq_i;
      end else if (win) begin
        if (!wr_act || supply_fault) win <= 1'b0;
        else begin
          wdata <= dq_i;
          if (addr != addr_lat) moved_q <= 1'b1;
        end
      end
      if (close_ev)    rec_cnt <= '0;
      else if (we_s)   begin if (!rec_ok) rec_cnt <= rec_cnt + 1'b1; end
      else if (!rec_ok) rec_cnt <= '0;
      if (we_s) we_lo_cnt <= '0;
      else if (we_lo_cnt != OW'(ODIS_DLY)) we_lo_cnt <= we_lo_cnt + 1'b1;
      if (ce_s || oe_s || addr != addr_q) acc_cnt <= '0;
      else if (acc_cnt != LW'(ACC_LAT)) acc_cnt <= acc_cnt + 1'b1;
    end

  always_ff @(posedge clk)
    if (commit) mem[addr_lat] <= wdata;

  wire drv   = !ce_s && !oe_s && (we_s || we_lo_cnt < OW'(ODIS_DLY));
  wire valid = acc_cnt == LW'(ACC_LAT) && addr == addr_q;

  assign dq_oe      = drv;
  assign dq_o       = (drv && valid) ? mem[addr] : '0;
  assign addr_moved = moved_q;
endmodule

// File: rtl/sram_bus_port_chk.sv
module sram_bus_port_chk #(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int RW       = 3,
  parameter int RECOVERY = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe,
  input logic          supply_fault,
  input logic          addr_moved,
  input logic          win,
  input logic [RW-1:0] rec_cnt
);
  p_drive_needs_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2)));

  p_zero_on_new_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> dq_o == '0);

  p_window_needs_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> (!$past(ce_n, 3) && !$past(we_n, 3)));

  p_open_after_recovery_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win) |-> $past(rec_cnt) == RW'(RECOVERY));

  p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fault |=> !win);

  p_moved_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win) |-> !addr_moved);
endmodule

bind sram_bus_port sram_bus_port_chk #(
  .AW(AW), .DW(DW), .RW(RW), .RECOVERY(RECOVERY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .addr(addr), .dq_o(dq_o), .dq_oe(dq_oe), .supply_fault(supply_fault),
  .addr_moved(addr_moved), .win(win), .rec_cnt(rec_cnt)
);

// File: tb/sim_sram_bus_port.sv
module sim_sram_bus_port;
  localparam int AW = 4, DW = 8, REC = 3, ODIS = 2, ACC = 2, N = 1 << AW;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, fault = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe, moved;
  logic [DW-1:0] model [N];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_bus_port #(.AW(AW), .DW(DW), .RECOVERY(REC), .ODIS_DLY(ODIS), .ACC_LAT(ACC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .dq_i(dq_i), .supply_fault(fault), .dq_o(dq_o), .dq_oe(dq_oe), .addr_moved(moved));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); dq_i = d; oe_n = 1; ce_n = 0; we_n = 0;
    cyc(5);
    we_n = 1; ce_n = 1;
    cyc(8);
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0;
    cyc(ACC + 3);
    d = dq_o;
    ce_n = 1; oe_n = 1;
    cyc(3);
  endtask

  task automatic sweep(int pat, string req);
    logic [DW-1:0] d;
    for (int a = 0; a < N; a++) begin
      d = (pat == 0) ? DW'(a * 37 + 5) : (pat == 1) ? ~DW'(a * 37 + 5) : DW'(1 << (a % DW));
      wr(a, d);
      model[a] = d;
    end
    for (int a = 0; a < N; a++) begin
      rd(a, d);
      chk(req, d, model[a]);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [DW-1:0] d;
    cyc(3);
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 moved in reset", moved, 0);
    rst_n = 1;
    cyc(3);
    chk("R1 dq_oe after reset", dq_oe, 0);
    // R1: first write after reset accepted, checked by the R2 sweep
    sweep(0, "R2 affine");
    sweep(1, "R2 complement");
    sweep(2, "R2 walking one");
    chk("R1 moved clear after clean writes", moved, 0);

    // R3: driver enable over chip-select / output-enable combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ce_n = c[0]; oe_n = c[1];
      cyc(1);
      chk("R3 not before sync", dq_oe, 0);
      cyc(1);
      chk("R3 drive combo", dq_oe, (c == 0) ? 1 : 0);
      ce_n = 1; oe_n = 1;
      cyc(3);
    end

    // R4: access latency from output enable, then from an address change
    @(negedge clk);
    addr = 3; ce_n = 0; oe_n = 0;
    cyc(2);
    chk("R4 drive on", dq_oe, 1);
    chk("R4 zero first", dq_o, 0);
    cyc(ACC - 1);
    chk("R4 zero until latency", dq_o, 0);
    cyc(1);
    chk("R4 data at latency", dq_o, model[3]);
    addr = 5;
    cyc(ACC);
    chk("R4 zero after addr change", dq_o, 0);
    cyc(1);
    chk("R4 new data", dq_o, model[5]);

    // R6: drivers turn off after a delay once the write strobe falls
    dq_i = 8'h5A; we_n = 0;
    cyc(1 + ODIS);
    chk("R6 still driving", dq_oe, 1);
    cyc(1);
    chk("R6 drivers off", dq_oe, 0);
    we_n = 1; ce_n = 1; oe_n = 1;
    model[5] = 8'h5A;
    cyc(8);
    rd(5, d); chk("R6 write during read stored", d, 8'h5A);

    // R5: strobe first, chip select ends it; later data ignored
    @(negedge clk);
    addr = 6; dq_i = 8'hC1; we_n = 0;
    cyc(4); ce_n = 0;
    cyc(5); ce_n = 1;
    cyc(3); dq_i = 8'hC2;
    cyc(4); we_n = 1;
    cyc(8);
    model[6] = 8'hC1;
    rd(6, d); chk("R5 strobe first", d, 8'hC1);
    // R5: chip select first, strobe ends it
    @(negedge clk);
    addr = 7; ce_n = 0;
    cyc(4); dq_i = 8'hC3; we_n = 0;
    cyc(5); we_n = 1;
    cyc(3); dq_i = 8'hC4;
    cyc(4); ce_n = 1;
    cyc(8);
    model[7] = 8'hC3;
    rd(7, d); chk("R5 select first", d, 8'hC3);
    // R5: last value inside the window wins
    @(negedge clk);
    addr = 8; dq_i = 8'hC5; ce_n = 0; we_n = 0;
    cyc(3); dq_i = 8'hC6;
    cyc(4); we_n = 1; ce_n = 1;
    cyc(8);
    model[8] = 8'hC6;
    rd(8, d); chk("R5 last data in window", d, 8'hC6);

    // R7: recovery gap at REC (ignored) and REC+1 (accepted)
    @(negedge clk);
    addr = 9; dq_i = 8'hE1; ce_n = 0; we_n = 0;
    cyc(5); we_n = 1;
    cyc(REC); addr = 10; dq_i = 8'hE2; we_n = 0;
    cyc(5); we_n = 1;
    cyc(REC + 1); addr = 11; dq_i = 8'hE3; we_n = 0;
    cyc(5); we_n = 1; ce_n = 1;
    cyc(8);
    model[9] = 8'hE1; model[11] = 8'hE3;
    rd(9, d);  chk("R7 first write", d, model[9]);
    rd(10, d); chk("R7 early cycle ignored", d, model[10]);
    rd(11, d); chk("R7 cycle after recovery", d, model[11]);

    // R8: fault before the write, and fault in mid-window
    fault = 1;
    wr(12, 8'hF1);
    fault = 0;
    rd(12, d); chk("R8 fault blocks write", d, model[12]);
    @(negedge clk);
    addr = 13; dq_i = 8'hF2; ce_n = 0; we_n = 0;
    cyc(4); fault = 1;
    cyc(2); fault = 0;
    cyc(2); we_n = 1; ce_n = 1;
    cyc(8);
    rd(13, d); chk("R8 fault aborts window", d, model[13]);

    // R9: address captured at open, change flagged
    @(negedge clk);
    addr = 14; dq_i = 8'h9D; ce_n = 0; we_n = 0;
    cyc(4); addr = 15;
    cyc(3); we_n = 1; ce_n = 1;
    cyc(6);
    chk("R9 moved set", moved, 1);
    model[14] = 8'h9D;
    rd(14, d); chk("R9 commit to latched addr", d, model[14]);
    rd(15, d); chk("R9 moved-to addr untouched", d, model[15]);
    chk("R9 moved held", moved, 1);
    wr(14, 8'h77);
    chk("R9 moved cleared by next window", moved, 0);
    model[14] = 8'h77;
    rd(14, d); chk("R9 clean rewrite", d, model[14]);

    finish_up();
  end
endmodule